// File: doc/BRIEF.md
# Split-Port Burst-of-Four Synchronous SRAM

This block is a synthesizable behavioural model of a small pipelined SRAM with two independent data paths: a write path with its own input data bus and a read path with its own output data bus. Because the buses are never shared, a read and a write can be in progress together and no idle cycle is ever spent turning a bus around. Each memory line holds four words, and every access moves all four of them as a burst, one word per beat.

Both ports share one address bus. The model runs on a single beat-rate clock, so one input-clock period spans two beats. A phase bit (`ph`) alternates the beat edges between a read slot and a write slot. It is cleared by reset, so the first edge after reset is a read slot. The read port FSM has two states, `RD_IDLE` and `RD_BURST`. A line address enters a two-stage delay line first, and `RD_IDLE -> RD_BURST` fires when that line leaves the delay line. `RD_BURST -> RD_BURST` (reload) fires when a queued read is waiting as the fourth beat leaves. `RD_BURST -> RD_IDLE` fires after the fourth beat when no read is waiting. The write port FSM also has two states, `WR_IDLE` and `WR_BURST`. `WR_IDLE -> WR_BURST` fires on an accepted write select. `WR_BURST -> WR_IDLE` fires on the fourth beat, and the whole line is written into the array on that same edge.

While a write burst is being assembled, its captured words are forwarded to any read of the same line. This includes a word captured on the same edge that a read beat is registered. A read therefore always returns the most recent data.

Top module: `qb4_sram`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rvalid` is 0 and `rdata` is 0. Every array word reads as 0 until it is written.
- R2: Edges are counted from 0 at the first rising clock edge after reset. `rd_sel_n` is honoured only on even edges, and `wr_sel_n` only on odd edges. A select that is low on the other port's slot has no effect.
- R3: An accepted write on edge t captures `wdata` on edges t, t+1, t+2 and t+3 as words 0, 1, 2 and 3 of the addressed line. `wr_sel_n` and `addr` are ignored on edges t+1 to t+3. The earliest next write is at edge t+4.
- R4: An accepted read on edge t produces words 0, 1, 2 and 3 of its line in that order. Each word is registered on one of the edges t+3 to t+6. `rvalid` is 1 exactly for those four beats.
- R5: A read select on the read slot right after an accepted read slot is ignored. Reads accepted 4 edges apart give 8 contiguous valid beats.
- R6: The line is selected by `addr[ADDR_W-1:2]`. The two low bits `addr[1:0]` never change the line or the word order.
- R7: A read beat for word j registered on edge e carries the value last written to word j of that line on an edge at or before e. This holds when the write burst is still being assembled, and when the word is captured on edge e itself.
- R8: Reads and writes run concurrently. A read of one line is not disturbed by a write burst to a different line that overlaps it in time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock; one beat per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared address bus; read slot on even edges, write slot on odd edges |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| wdata | input | WORD_W | Write data, one word per beat |
| rdata | output | WORD_W | Read data, one word per beat |
| rvalid | output | 1 | High for each beat that carries read data |

## Verification
The hardest situation to reach is a read beat that must take a word from a write burst that is still assembling. This includes the word captured on the very edge that the read beat is registered, and the case where the write burst starts after the read was accepted. The stimulus issues reads and writes to the same line at every relative offset from one to five edges. It also holds both selects low continuously, so that ignored wrong-slot and busy selects are mixed with accepted ones. A reference array that is updated on every captured beat then gives the expected word for each read beat.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
    localparam int BEATS = 4;
    typedef logic [1:0] beat_t;
    typedef enum logic { WR_IDLE, WR_BURST } wr_state_t;
    typedef enum logic { RD_IDLE, RD_BURST } rd_state_t;
endpackage

// File: rtl/qb4_array.sv
module qb4_array
    import qb4_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 18,
    localparam int LINE_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic [BEATS*WORD_W-1:0] wr_data,
    input  logic [LINE_W-1:0]       rd_line,
    input  beat_t                   rd_beat,
    output logic [WORD_W-1:0]       rd_word
);
    logic [BEATS*WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[wr_line] <= wr_data;
        end
    end

    always_comb begin
        rd_word = mem[rd_line][rd_beat*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/qb4_wr_assembler.sv
module qb4_wr_assembler
    import qb4_pkg::*;
#(
    parameter int LINE_W = 6,
    parameter int WORD_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_slot,
    input  logic                    wr_sel_n,
    input  logic [LINE_W-1:0]       line_in,
    input  logic [WORD_W-1:0]       wdata,
    output logic                    busy,
    output beat_t                   cnt,
    output logic [LINE_W-1:0]       buf_line,
    output logic [BEATS*WORD_W-1:0] held_flat,
    output logic                    cap,
    output logic [LINE_W-1:0]       cap_line,
    output beat_t                   cap_beat,
    output logic                    commit,
    output logic [BEATS*WORD_W-1:0] commit_data
);
    wr_state_t state, state_nx;
    logic [WORD_W-1:0] held [BEATS];
    logic start;

    always_comb begin
        start    = (state == WR_IDLE) && wr_slot && !wr_sel_n;
        state_nx = state;
        unique case (state)
            WR_IDLE:  if (start) state_nx = WR_BURST;
            WR_BURST: if (cnt == beat_t'(BEATS-1)) state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            buf_line <= '0;
            for (int i = 0; i < BEATS; i++) held[i] <= '0;
        end else begin
            unique case (state)
                WR_IDLE: begin
                    if (start) begin
                        buf_line <= line_in;
                        held[0]  <= wdata;
                        cnt      <= beat_t'(1);
                    end
                end
                WR_BURST: begin
                    held[cnt] <= wdata;
                    cnt       <= cnt + beat_t'(1);
                end
            endcase
        end
    end

    always_comb begin
        busy     = (state == WR_BURST);
        cap      = start || busy;
        cap_line = busy ? buf_line : line_in;
        cap_beat = busy ? cnt : beat_t'(0);
        commit   = busy && (cnt == beat_t'(BEATS-1));
        commit_data = {wdata, held[2], held[1], held[0]};
    end

    genvar g;
    generate
        for (g = 0; g < BEATS; g++) begin : g_flat
            assign held_flat[g*WORD_W +: WORD_W] = held[g];
        end
    endgenerate
endmodule

// File: rtl/qb4_rd_engine.sv
module qb4_rd_engine
    import qb4_pkg::*;
#(
    parameter int LINE_W = 6,
    parameter int WORD_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_slot,
    input  logic                    rd_sel_n,
    input  logic [LINE_W-1:0]       line_in,
    input  logic                    wr_busy,
    input  beat_t                   wr_cnt,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic [BEATS*WORD_W-1:0] wr_held,
    input  logic                    wr_cap,
    input  logic [LINE_W-1:0]       wr_cap_line,
    input  beat_t                   wr_cap_beat,
    input  logic [WORD_W-1:0]       wdata,
    input  logic [WORD_W-1:0]       mem_word,
    output logic [LINE_W-1:0]       look_line,
    output beat_t                   look_beat,
    output logic                    accept,
    output logic                    rvalid,
    output logic [WORD_W-1:0]       rdata
);
    rd_state_t state, state_nx;
    logic              last_acc;
    logic              s1_v, s2_v;
    logic [LINE_W-1:0] s1_line, s2_line, r_line;
    beat_t             r_cnt;
    logic              load;
    logic [WORD_W-1:0] fwd_word;

    always_comb begin
        accept   = rd_slot && !rd_sel_n && !last_acc;
        load     = s2_v && ((state == RD_IDLE) || (r_cnt == beat_t'(BEATS-1)));
        state_nx = state;
        unique case (state)
            RD_IDLE:  if (load) state_nx = RD_BURST;
            RD_BURST: if (r_cnt == beat_t'(BEATS-1) && !load) state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_acc <= 1'b0;
            s1_v     <= 1'b0;
            s2_v     <= 1'b0;
            s1_line  <= '0;
            s2_line  <= '0;
            r_line   <= '0;
            r_cnt    <= '0;
        end else begin
            if (rd_slot) last_acc <= accept;
            s1_v    <= accept;
            s1_line <= line_in;
            s2_v    <= s1_v;
            s2_line <= s1_line;
            if (load) begin
                r_line <= s2_line;
                r_cnt  <= '0;
            end else if (state == RD_BURST) begin
                r_cnt  <= r_cnt + beat_t'(1);
            end
        end
    end

    always_comb begin
        look_line = r_line;
        look_beat = r_cnt;
        if (wr_cap && wr_cap_line == r_line && wr_cap_beat == r_cnt)
            fwd_word = wdata;
        else if (wr_busy && wr_line == r_line && r_cnt < wr_cnt)
            fwd_word = wr_held[r_cnt*WORD_W +: WORD_W];
        else
            fwd_word = mem_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            unique case (state)
                RD_IDLE:  rvalid <= 1'b0;
                RD_BURST: begin
                    rvalid <= 1'b1;
                    rdata  <= fwd_word;
                end
            endcase
        end
    end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 18,
    localparam int LINE_W = $clog2(DEPTH),
    localparam int ADDR_W = LINE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic                    ph;
    logic [LINE_W-1:0]       line_in;
    logic                    wr_busy, wr_cap, wr_commit, rd_accept;
    beat_t                   wr_cnt, wr_cap_beat, look_beat;
    logic [LINE_W-1:0]       wr_line, wr_cap_line, look_line;
    logic [BEATS*WORD_W-1:0] wr_held, commit_data;
    logic [WORD_W-1:0]       mem_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    assign line_in = addr[ADDR_W-1:2];

    qb4_wr_assembler #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_slot(ph), .wr_sel_n(wr_sel_n),
        .line_in(line_in), .wdata(wdata), .busy(wr_busy), .cnt(wr_cnt),
        .buf_line(wr_line), .held_flat(wr_held), .cap(wr_cap),
        .cap_line(wr_cap_line), .cap_beat(wr_cap_beat),
        .commit(wr_commit), .commit_data(commit_data)
    );

    qb4_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_commit), .wr_line(wr_line),
        .wr_data(commit_data), .rd_line(look_line), .rd_beat(look_beat),
        .rd_word(mem_word)
    );

    qb4_rd_engine #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_slot(~ph), .rd_sel_n(rd_sel_n),
        .line_in(line_in), .wr_busy(wr_busy), .wr_cnt(wr_cnt),
        .wr_line(wr_line), .wr_held(wr_held), .wr_cap(wr_cap),
        .wr_cap_line(wr_cap_line), .wr_cap_beat(wr_cap_beat),
        .wdata(wdata), .mem_word(mem_word), .look_line(look_line),
        .look_beat(look_beat), .accept(rd_accept),
        .rvalid(rvalid), .rdata(rdata)
    );
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic ph,
    input logic rvalid,
    input logic wr_busy,
    input logic wr_commit
);
    logic [7:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run <= '0;
        else if (rvalid) run <= run + 8'd1;
        else             run <= '0;
    end

    // R1: output quiet on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> !rvalid);

    // R2: first beat of every burst follows a read-slot edge pattern
    a_r2_first_beat_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> !ph);

    // R3: write burst holds until its commit beat
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !wr_commit) |=> wr_busy);

    // R4: valid runs come in whole bursts of four
    a_r4_run_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!rvalid && run != 8'd0) |-> (run[1:0] == 2'b00));
endmodule

bind qb4_sram qb4_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph(ph), .rvalid(rvalid),
    .wr_busy(wr_busy), .wr_commit(wr_commit)
);

// File: tb/tb_qb4_sram.sv
module tb_qb4_sram;
    localparam int DEPTH  = 64;
    localparam int WORD_W = 18;
    localparam int ADDR_W = $clog2(DEPTH) + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;
    logic              rvalid;

    qb4_sram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit started = 0, finished = 0;
    logic [WORD_W-1:0] model [DEPTH][4];
    int q_line[$], q_t[$];
    bit last_racc = 0;
    int wleft = 0, wcur = 0;
    logic [WORD_W-1:0] seq = 18'h00101;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one beat per call; the bench's own acceptance rules predict the design
    task automatic step(input bit rq, input int ra, input bit wq, input int wa);
        int wbeat;
        bit rd_go;
        rd_sel_n = !rq;
        wr_sel_n = !wq;
        rd_go = 0;
        wbeat = -1;
        if (cyc % 2 == 0) begin
            addr  = {ra[5:0], 2'(cyc / 2)};          // R6: low bits vary
            rd_go = rq && !last_racc;                // R2 R5
            last_racc = rd_go;
        end else begin
            addr = {wa[5:0], 2'(cyc / 2 + 1)};
        end
        if (wleft > 0) begin
            wbeat = 4 - wleft;
            wleft--;
        end else if (cyc % 2 == 1 && wq) begin       // R3
            wbeat = 0;
            wcur  = wa;
            wleft = 3;
        end
        if (wbeat >= 0) begin
            seq   = seq + 18'h00d37;
            wdata = seq;
        end else begin
            wdata = 18'h3ffff ^ 18'(cyc);
        end
        @(posedge clk);
        if (wbeat >= 0) model[wcur][wbeat] = wdata;  // R7: visible from this edge
        if (rd_go) begin
            q_line.push_back(ra);
            q_t.push_back(cyc);
        end
        cyc++;
        @(negedge clk);
    endtask

    // Monitor: compares each registered beat at the negedge after its edge
    always @(negedge clk) begin
        if (started && !finished) begin
            int e, j;
            e = cyc - 1;
            j = -1;
            if (q_t.size() > 0) j = e - q_t[0] - 3;
            if (j >= 0 && j <= 3) begin
                check(rvalid === 1'b1, "R4", "rvalid beat", 18'(rvalid), 18'd1);
                check(rdata === model[q_line[0]][j], "R7", "read word",
                      rdata, model[q_line[0]][j]);
                if (j == 3) begin
                    void'(q_line.pop_front());
                    void'(q_t.pop_front());
                end
            end else begin
                check(rvalid === 1'b0, "R5", "rvalid idle", 18'(rvalid), 18'd0);
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++)
            for (int k = 0; k < 4; k++) model[i][k] = '0;
        repeat (3) @(negedge clk);
        check(rvalid === 1'b0, "R1", "rvalid in reset", 18'(rvalid), 18'd0);
        check(rdata === '0, "R1", "rdata in reset", rdata, 18'd0);
        rst_n = 1'b1;
        started = 1;
        check(rvalid === 1'b0, "R1", "rvalid after reset", 18'(rvalid), 18'd0);
        // R1 R6: unwritten line reads zero, low address bits set
        step(1, 5, 0, 0);
        repeat (9) step(0, 0, 0, 0);
        // R3: write line 5, then read it back (R4 R6)
        step(0, 0, 0, 0); step(0, 0, 1, 5);
        repeat (4) step(0, 0, 0, 0);
        step(1, 5, 0, 0);
        repeat (9) step(0, 0, 0, 0);
        // R7: read and write the same line at offsets of 1 to 5 edges
        for (int off = 1; off <= 5; off += 2) begin
            step(1, 9 + off, 0, 0);
            for (int k = 1; k < off; k++) step(0, 0, 0, 0);
            step(0, 0, 1, 9 + off);
            repeat (10) step(0, 0, 0, 0);
        end
        for (int off = 1; off <= 5; off += 2) begin
            step(0, 0, 0, 0);
            step(0, 0, 1, 20 + off);
            for (int k = 1; k < off; k++) step(0, 0, 0, 0);
            step(1, 20 + off, 0, 0);
            repeat (10) step(0, 0, 0, 0);
        end
        // R5 R8: back-to-back reads and writes on different lines
        for (int n = 0; n < 8; n++) begin
            step(1, 30 + n, 0, 0); step(0, 0, 1, 40 + n);
            step(0, 0, 0, 0);      step(0, 0, 0, 0);
        end
        repeat (10) step(0, 0, 0, 0);
        for (int n = 0; n < 8; n++) begin
            step(1, 40 + n, 0, 0); step(0, 0, 0, 0);
            step(0, 0, 0, 0);      step(0, 0, 0, 0);
        end
        // R2 R3 R5: both selects held low on every edge
        for (int n = 0; n < 40; n++) step(1, 40 + (n % 6), 1, 42 + (n % 5));
        repeat (12) step(0, 0, 0, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule